// File: doc/BRIEF.md
# Serial EEPROM Word Reader

This block fetches one 16-bit word from a three-wire serial EEPROM using the read command. The host gives it a word address and a one-cycle `start`. The block raises chip select and sends the read opcode and then the address, most significant bit first. It then clocks in sixteen data bits. It ends the transfer with a fixed closing sequence and returns the word together with a one-cycle `done`.

The serial clock is much slower than the system clock. Its levels and the data setup times all come from the `CLKS_PER_US` parameter, which gives the number of system clock cycles per microsecond:

- Each serial clock level lasts `9*CLKS_PER_US` cycles (`LVL_CYC`).
- Each data setup interval lasts `ceil(0.4*CLKS_PER_US)` cycles, and at least one cycle (`SU_CYC`).

The request side follows a ready/accept rule:

- `busy` low means the block is ready.
- A `start` is taken only in a cycle where `busy` is low.
- A `start` that arrives while `busy` is high is dropped, so there is no back-pressure to hold.
- The result side has no stall: `rdata` is valid in the `done` cycle and stays unchanged until the data phase of the next read.

Top module: `ee_word_reader`

## Requirements
- R1: While reset is held and while idle, `ee_cs`, `ee_sk`, `ee_di`, `busy` and `done` are all 0, and `rdata` resets to 0.
- R2: A `start` sampled with `busy` low makes `busy` and `ee_cs` high from the next cycle.
- R3: While `ee_cs` is high, the first 9 rising `ee_sk` edges carry the command: opcode 3'b110 in bits 8:6, then the 6-bit address in bits 5:0, sent most significant bit first.
- R4: `ee_di` is stable for at least `SU_CYC` cycles before each rising `ee_sk` edge, and it does not change while `ee_sk` is high.
- R5: Every `ee_sk` high level, and every low level between two pulses of one read, lasts at least `LVL_CYC = 9*CLKS_PER_US` cycles.
- R6: `ee_di` is 0 from the end of the last command bit to the end of the read.
- R7: Rising edges 10 to 25 of a read are data bits, taken from `ee_do` while `ee_sk` is high and placed into `rdata` most significant bit first.
- R8: After the last data bit, `ee_cs` and `ee_di` are low, and then exactly one full `ee_sk` pulse follows with `ee_cs` low. A read therefore has exactly 26 rising edges, and all pins are low at its end.
- R9: `done` is high for exactly one cycle, `busy` is low in that cycle, and `rdata` keeps its value in the cycles after it.
- R10: A `start` while `busy` is high is ignored. The running read keeps its address and data, and no second read follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | active-low asynchronous reset |
| start | input | 1 | request strobe, accepted when `busy` is low |
| addr | input | ADDR_W (6) | word address, captured with an accepted `start` |
| busy | output | 1 | a read is in progress (not ready) |
| done | output | 1 | one-cycle pulse at the end of a read |
| rdata | output | DATA_W (16) | word read from the EEPROM |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | serial data to the EEPROM |
| ee_do | input | 1 | serial data from the EEPROM |

## Verification
A state machine that skips or repeats a phase shows up on the pins within one serial clock level. It would show as one of:

- a command with the wrong bit count or value;
- a serial clock level shorter than `LVL_CYC`;
- a wrong rising-edge count, which becomes visible at the closing pulse.

A slip in the bit counter or the shift register shows up only at `done`, about 26 serial clock periods later. It appears as a word that is shifted or truncated compared with the stored value. A timer that loads the wrong length breaks the level or setup rule at the very next edge.

// File: rtl/ee_rd_pkg.sv
package ee_rd_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SETUP,
    ST_CMD_HI,
    ST_CMD_LO,
    ST_TAIL,
    ST_RD_HI,
    ST_RD_LO,
    ST_CS_OFF,
    ST_END_HI,
    ST_END_LO
  } ee_state_e;

  // cycles for a setup interval of 0.4 us, rounded up, at least one
  function automatic int unsigned setup_cycles(int unsigned clks_per_us);
    int unsigned c;
    c = (4 * clks_per_us + 9) / 10;
    return (c == 0) ? 1 : c;
  endfunction

endpackage

// File: rtl/ee_rd_timer.sv
module ee_rd_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/ee_rd_shifter.sv
module ee_rd_shifter #(
  parameter int CMD_W  = 9,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_cmd,
  input  logic [CMD_W-1:0]  cmd_in,
  input  logic              shift_cmd,
  output logic              cmd_msb,
  input  logic              shift_data,
  input  logic              din,
  output logic [DATA_W-1:0] data_out
);

  logic [CMD_W-1:0]  cmd_sr;
  logic [DATA_W-1:0] data_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cmd_sr <= '0;
    else if (load_cmd)  cmd_sr <= cmd_in;
    else if (shift_cmd) cmd_sr <= {cmd_sr[CMD_W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          data_sr <= '0;
    else if (shift_data) data_sr <= {data_sr[DATA_W-2:0], din};
  end

  assign cmd_msb  = cmd_sr[CMD_W-1];
  assign data_out = data_sr;

endmodule

// File: rtl/ee_rd_fsm.sv
module ee_rd_fsm
  import ee_rd_pkg::*;
#(
  parameter int CMD_W  = 9,
  parameter int DATA_W = 16,
  parameter int SU_CYC = 1,
  parameter int LVL_CYC = 18,
  parameter int TW     = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          timer_exp,
  input  logic          cmd_msb,
  output logic          timer_load,
  output logic [TW-1:0] timer_val,
  output logic          load_cmd,
  output logic          shift_cmd,
  output logic          shift_data,
  output logic          busy,
  output logic          done,
  output logic          cs,
  output logic          sk,
  output logic          di
);

  localparam int MAXB = (CMD_W > DATA_W) ? CMD_W : DATA_W;
  localparam int BW   = $clog2(MAXB + 1);
  localparam logic [TW-1:0] SU_M1  = TW'(SU_CYC - 1);
  localparam logic [TW-1:0] LVL_M1 = TW'(LVL_CYC - 1);
  localparam logic [BW-1:0] CMD_LAST  = BW'(CMD_W - 1);
  localparam logic [BW-1:0] DATA_LAST = BW'(DATA_W - 1);

  ee_state_e st, nxt;
  logic [BW-1:0] bit_cnt, bit_nxt;
  logic done_q;

  always_comb begin
    nxt        = st;
    bit_nxt    = bit_cnt;
    timer_load = 1'b0;
    timer_val  = '0;
    load_cmd   = 1'b0;
    shift_cmd  = 1'b0;
    shift_data = 1'b0;
    case (st)
      ST_IDLE: if (start) begin
        nxt = ST_SETUP; timer_load = 1'b1; timer_val = SU_M1;
        load_cmd = 1'b1; bit_nxt = '0;
      end
      ST_SETUP: if (timer_exp) begin
        nxt = ST_CMD_HI; timer_load = 1'b1; timer_val = LVL_M1;
      end
      ST_CMD_HI: if (timer_exp) begin
        nxt = ST_CMD_LO; timer_load = 1'b1; timer_val = LVL_M1;
      end
      ST_CMD_LO: if (timer_exp) begin
        timer_load = 1'b1; timer_val = SU_M1;
        if (bit_cnt == CMD_LAST) begin
          nxt = ST_TAIL; bit_nxt = '0;
        end else begin
          nxt = ST_SETUP; shift_cmd = 1'b1; bit_nxt = bit_cnt + 1'b1;
        end
      end
      ST_TAIL: if (timer_exp) begin
        nxt = ST_RD_HI; timer_load = 1'b1; timer_val = LVL_M1;
      end
      ST_RD_HI: if (timer_exp) begin
        nxt = ST_RD_LO; timer_load = 1'b1; timer_val = LVL_M1;
        shift_data = 1'b1;
      end
      ST_RD_LO: if (timer_exp) begin
        timer_load = 1'b1;
        if (bit_cnt == DATA_LAST) begin
          nxt = ST_CS_OFF; timer_val = SU_M1; bit_nxt = '0;
        end else begin
          nxt = ST_RD_HI; timer_val = LVL_M1; bit_nxt = bit_cnt + 1'b1;
        end
      end
      ST_CS_OFF: if (timer_exp) begin
        nxt = ST_END_HI; timer_load = 1'b1; timer_val = LVL_M1;
      end
      ST_END_HI: if (timer_exp) begin
        nxt = ST_END_LO; timer_load = 1'b1; timer_val = LVL_M1;
      end
      ST_END_LO: if (timer_exp) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      bit_cnt <= '0;
      done_q  <= 1'b0;
    end else begin
      st      <= nxt;
      bit_cnt <= bit_nxt;
      done_q  <= (st == ST_END_LO) && timer_exp;
    end
  end

  always_comb begin
    cs = 1'b0; sk = 1'b0; di = 1'b0;
    case (st)
      ST_SETUP, ST_CMD_LO: begin cs = 1'b1; di = cmd_msb; end
      ST_CMD_HI:           begin cs = 1'b1; sk = 1'b1; di = cmd_msb; end
      ST_TAIL, ST_RD_LO:   cs = 1'b1;
      ST_RD_HI:            begin cs = 1'b1; sk = 1'b1; end
      ST_END_HI:           sk = 1'b1;
      default: ;
    endcase
  end

  assign busy = (st != ST_IDLE);
  assign done = done_q;

endmodule

// File: rtl/ee_word_reader.sv
module ee_word_reader
  import ee_rd_pkg::*;
#(
  parameter int CLKS_PER_US = 50,
  parameter int ADDR_W      = 6,
  parameter int OP_W        = 3,
  parameter logic [OP_W-1:0] RD_OPCODE = 3'b110,
  parameter int DATA_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] addr,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              ee_cs,
  output logic              ee_sk,
  output logic              ee_di,
  input  logic              ee_do
);

  localparam int CMD_W   = OP_W + ADDR_W;
  localparam int LVL_CYC = 9 * CLKS_PER_US;
  localparam int SU_CYC  = int'(setup_cycles(CLKS_PER_US));
  localparam int TW      = $clog2(LVL_CYC + 1);

  logic          t_load, t_exp;
  logic [TW-1:0] t_val;
  logic          ld_cmd, sh_cmd, sh_dat, cmd_bit;

  ee_rd_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .expired(t_exp)
  );

  ee_rd_shifter #(.CMD_W(CMD_W), .DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .load_cmd(ld_cmd), .cmd_in({RD_OPCODE, addr}), .shift_cmd(sh_cmd),
    .cmd_msb(cmd_bit), .shift_data(sh_dat), .din(ee_do), .data_out(rdata)
  );

  ee_rd_fsm #(
    .CMD_W(CMD_W), .DATA_W(DATA_W), .SU_CYC(SU_CYC), .LVL_CYC(LVL_CYC), .TW(TW)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .timer_exp(t_exp), .cmd_msb(cmd_bit),
    .timer_load(t_load), .timer_val(t_val), .load_cmd(ld_cmd), .shift_cmd(sh_cmd),
    .shift_data(sh_dat), .busy(busy), .done(done),
    .cs(ee_cs), .sk(ee_sk), .di(ee_di)
  );

endmodule

// File: rtl/ee_word_reader_chk.sv
module ee_word_reader_chk #(
  parameter int LVL_CYC = 18
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic ee_cs,
  input logic ee_sk,
  input logic ee_di
);

  localparam int HW = $clog2(LVL_CYC + 2) + 1;
  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              hi_cnt <= '0;
    else if (!ee_sk)         hi_cnt <= '0;
    else if (hi_cnt != '1)   hi_cnt <= hi_cnt + 1'b1;
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ee_cs && !ee_sk && !ee_di));

  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && ee_cs));

  p_di_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_sk && $past(ee_sk)) |-> (ee_di == $past(ee_di)));

  p_high_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ee_sk) |-> (hi_cnt >= HW'(LVL_CYC)));

  p_cs_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ee_cs) |-> (!ee_di && !ee_sk));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

bind ee_word_reader ee_word_reader_chk #(.LVL_CYC(LVL_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di)
);

// File: tb/ee_word_reader_tb.sv
module ee_word_reader_tb;

  localparam int CPU     = 2;
  localparam int LVL_CYC = 9 * CPU;
  localparam int SU_CYC  = ((4 * CPU + 9) / 10 == 0) ? 1 : (4 * CPU + 9) / 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [5:0]  addr = '0;
  logic        busy, done, ee_cs, ee_sk, ee_di;
  logic        ee_do = 1'b0;
  logic [15:0] rdata;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  logic [15:0] mem [64];

  ee_word_reader #(.CLKS_PER_US(CPU)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .addr(addr), .busy(busy), .done(done),
    .rdata(rdata), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do)
  );

  always #2 clk = ~clk;

  function automatic logic [8:0] exp_cmd(input logic [5:0] a);
    return {3'b110, a};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      summary();
    end
  end

  // EEPROM model and pin monitor
  logic       p_cs = 1'b0, p_sk = 1'b0, p_di = 1'b0;
  int         rise_idx = 0, di_run = 0, hi_run = 0, lo_run = 0;
  bit         fall_seen = 1'b0;
  logic [8:0] got_cmd = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (ee_cs && !p_cs) begin
        rise_idx = 0; got_cmd = '0; fall_seen = 1'b0;
      end
      if (ee_di == p_di) di_run++; else di_run = 1;
      if (ee_sk && !p_sk) begin
        rise_idx++;
        check(di_run > SU_CYC, "R4 setup", di_run, SU_CYC + 1);
        if (fall_seen) check(lo_run >= LVL_CYC, "R5 low", lo_run, LVL_CYC);
        if (rise_idx <= 9) begin
          check(ee_cs, "R3 cs", ee_cs, 1);
          got_cmd = {got_cmd[7:0], ee_di};
        end else begin
          check(!ee_di, "R6 di", ee_di, 0);
        end
        if (rise_idx >= 10 && rise_idx <= 25) begin
          check(ee_cs, "R7 cs", ee_cs, 1);
          ee_do = mem[got_cmd[5:0]][25 - rise_idx];
        end
        if (rise_idx >= 26) check(!ee_cs, "R8 cs", ee_cs, 0);
        hi_run = 1;
      end else if (ee_sk) begin
        hi_run++;
      end
      if (ee_sk && p_sk) check(ee_di == p_di, "R4 hold", ee_di, p_di);
      if (!ee_sk && p_sk) begin
        check(hi_run >= LVL_CYC, "R5 high", hi_run, LVL_CYC);
        fall_seen = 1'b1;
        lo_run = 1;
      end else if (!ee_sk) begin
        lo_run++;
      end
      p_cs = ee_cs; p_sk = ee_sk; p_di = ee_di;
    end
  end

  task automatic do_read(input logic [5:0] a, input bit poke);
    int n;
    @(negedge clk);
    addr = a; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy, "R2 busy", busy, 1);
    check(ee_cs, "R2 cs", ee_cs, 1);
    n = 0;
    while (!done && n < 4000) begin
      @(negedge clk);
      n++;
      if (poke) begin
        start = (n == 40);
        if (n == 40) addr = ~a;
      end
    end
    start = 1'b0;
    check(n < 4000, "R9 done seen", n, 0);
    check(!busy, "R9 busy", busy, 0);
    check(rdata == mem[a], "R7 rdata", rdata, mem[a]);
    check(got_cmd == exp_cmd(a), "R3 cmd", got_cmd, exp_cmd(a));
    check(rise_idx == 26, "R8 pulses", rise_idx, 26);
    check(!ee_cs && !ee_sk && !ee_di, "R8 pins", {ee_cs, ee_sk, ee_di}, 0);
    @(negedge clk);
    check(!done, "R9 pulse", done, 0);
    check(rdata == mem[a], "R9 held", rdata, mem[a]);
    if (poke) begin
      repeat (20) @(negedge clk);
      check(!busy && !ee_cs, "R10 no rerun", {busy, ee_cs}, 0);
      check(rdata == mem[a], "R10 data", rdata, mem[a]);
    end
  endtask

  initial begin
    int unsigned dummy;
    dummy = $urandom(32'd7151);
    for (int i = 0; i < 64; i++) mem[i] = 16'($urandom);
    mem[0]  = 16'hFFFF;
    mem[1]  = 16'h0000;
    mem[63] = 16'h8001;
    mem[42] = 16'h5AA5;
    repeat (4) @(negedge clk);
    check({busy, done, ee_cs, ee_sk, ee_di} == 5'b0, "R1 in reset",
          {busy, done, ee_cs, ee_sk, ee_di}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check({busy, done, ee_cs, ee_sk, ee_di} == 5'b0 && rdata == 16'h0, "R1 idle",
          {busy, done, ee_cs, ee_sk, ee_di, rdata}, 0);
    do_read(6'd0, 1'b0);
    do_read(6'd63, 1'b0);
    do_read(6'd1, 1'b0);
    do_read(6'd42, 1'b1);
    for (int k = 0; k < 20; k++) begin
      do_read(6'($urandom), (k % 7) == 3);
      repeat (1 + ($urandom % 5)) @(negedge clk);
    end
    do_read(6'd21, 1'b0);
    summary();
  end

endmodule